// File: doc/BRIEF.md
# Consecutive-Sample Input Debouncer

This block cleans up one asynchronous digital input. The raw level first passes through a short synchronizer chain into the system clock domain. After that, it is examined only on cycles where an external filter-clock strobe is asserted. The output level changes only when the synchronized input has shown the opposite level on a programmed number of strobes in a row. The rule is the same for rising and falling edges.

A short excursion that does not last for the required run of strobes is discarded. Whether a pulse of roughly threshold width gets through depends on where the strobes fall relative to it. The accepted edge can also appear up to one strobe period late, so the output edge carries jitter of up to one filter period.

A per-input enable bypasses the filter. While the enable is low, the output is the synchronized input. During that time the filter state silently follows the input, so the output does not jump when filtering is switched back on.

Top module: `pin_glitch_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the filtered level and the run counter are cleared, so `dout` reads 0 after reset.
- R2: With `filt_en` low, `dout` equals `din_async` delayed by exactly `SYNC_STAGES` (default 2) system clock edges.
- R3: With `filt_en` high, `dout` rises only after the synchronized input has been 1 on `hold_count` consecutive `tick` cycles while `dout` was 0. The change becomes visible one clock after the last of those ticks.
- R4: A falling transition is accepted under the same rule as R3, with the levels swapped.
- R5: On a `tick` where the synchronized input equals the current output level, the run counter returns to zero. Any later attempt has to start a new run of `hold_count` ticks.
- R6: On cycles where `tick` is 0, the filtered level and the run counter do not change, whatever the input does.
- R7: A `hold_count` of 0 is treated as 1: the first differing tick is accepted.
- R8: While `filt_en` is low, the filtered level tracks the synchronized input and the counter stays at zero. When `filt_en` is raised with a steady input, `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din_async | input | 1 | Raw asynchronous input |
| tick | input | 1 | Filter-clock strobe; the input is examined on cycles where it is 1 |
| hold_count | input | CNT_W (8) | Number of consecutive agreeing ticks needed to accept a new level |
| filt_en | input | 1 | 1 = filtered output, 0 = synchronized pass-through |
| dout | output | 1 | Cleaned output level |

## Verification
Two functions can meet in one cycle: the tick that completes a run, and the input returning to the old level. The bench provokes this by holding the input for `hold_count` minus one ticks and then dropping it in the cycle before the deciding tick. The second collision is switching `filt_en` back on in a cycle that also carries a tick. In both cases a behavioural model of the sync delay and run count gives the expected output, and the two are compared on every clock. Randomised input runs with random strobe spacing and thresholds push many pulses close to the threshold width, where phase alone decides the result.

// File: rtl/gf_pkg.sv
// Package: shared parameters for the debouncer.
// Assumes: all users import the same default widths.
package gf_pkg;
    localparam int unsigned GF_CNT_W_DEF  = 8;
    localparam int unsigned GF_SYNC_DEF   = 2;
endpackage

// File: rtl/gf_sync.sv
// Module: gf_sync - a multi-flop synchronizer into the clk domain.
// Assumes: STAGES >= 2. The reset value is 0.
module gf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    // First stage captures the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gf_qualifier.sv
// Module: gf_qualifier - holds the accepted level and counts the consecutive
// ticks on which the sample disagrees with it.
// Assumes: smp is already synchronous. A need value of 0 acts as 1.
module gf_qualifier #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             smp,
    input  logic [CNT_W-1:0] need,
    output logic             lvl,
    output logic [CNT_W-1:0] run_cnt
);
    logic [CNT_W:0] need_eff;
    logic [CNT_W:0] run_next;
    logic           reached;

    // Build the effective threshold and decide whether this tick finishes a run.
    always_comb begin
        need_eff = (need == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, need};
        run_next = {1'b0, run_cnt} + {{CNT_W{1'b0}}, 1'b1};
        reached  = (run_next >= need_eff);
    end

    // Update the level and the run counter on ticks, or follow the input in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl     <= 1'b0;
            run_cnt <= '0;
        end else if (!en) begin
            lvl     <= smp;
            run_cnt <= '0;
        end else if (tick) begin
            if (smp == lvl) begin
                run_cnt <= '0;
            end else if (reached) begin
                lvl     <= smp;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_next[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pin_glitch_filter.sv
// Module: pin_glitch_filter - top of the per-input debouncer.
// Assumes: tick is a one-cycle strobe in the clk domain, and hold_count and
// filt_en are quasi-static.
module pin_glitch_filter
    import gf_pkg::*;
#(
    parameter int unsigned CNT_W       = GF_CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = GF_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_async,
    input  logic             tick,
    input  logic [CNT_W-1:0] hold_count,
    input  logic             filt_en,
    output logic             dout
);
    logic             sync_lvl;
    logic             filt_lvl;
    logic [CNT_W-1:0] run_cnt;

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (din_async),
        .d_out (sync_lvl)
    );

    gf_qualifier #(.CNT_W(CNT_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (filt_en),
        .smp     (sync_lvl),
        .need    (hold_count),
        .lvl     (filt_lvl),
        .run_cnt (run_cnt)
    );

    // Choose between the filtered level and the plain synchronized level.
    always_comb begin
        dout = filt_en ? filt_lvl : sync_lvl;
    end
endmodule

// File: rtl/gf_checker.sv
// Module: gf_checker - temporal properties of the debouncer, bound to the top.
// Assumes: its ports are connected to the top's internal nets by the bind below.
module gf_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             filt_en,
    input logic             sync_lvl,
    input logic             filt_lvl,
    input logic [CNT_W-1:0] run_cnt,
    input logic             dout
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (filt_lvl == 1'b0 && run_cnt == '0));

    assert_bypass_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> (filt_lvl == $past(sync_lvl) && run_cnt == '0));

    assert_quiet_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !tick) |=> ($stable(filt_lvl) && $stable(run_cnt)));

    assert_agree_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && tick && sync_lvl == filt_lvl) |=> (run_cnt == '0 && $stable(filt_lvl)));

    assert_rise_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $rose(filt_lvl)) |-> $past(sync_lvl));

    assert_fall_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $fell(filt_lvl)) |-> !$past(sync_lvl));
endmodule

bind pin_glitch_filter gf_checker #(.CNT_W(CNT_W)) u_gf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .filt_en  (filt_en),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl),
    .run_cnt  (run_cnt),
    .dout     (dout)
);

// File: tb/pin_glitch_filter_tb.sv
module pin_glitch_filter_tb;
    localparam int CLK_P = 10;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din_async = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] hold_count = 8'd5;
    logic          filt_en = 1'b0;
    logic          dout;

    int    checks = 0;
    int    bad = 0;
    string phase = "R1";
    int    tick_div = 0;
    int    tick_ctr = 0;
    bit    done = 0;

    // Behavioural reference state.
    int q[$] = '{0, 0};
    int m_lvl = 0;
    int m_cnt = 0;

    pin_glitch_filter u_dut (
        .clk(clk), .rst_n(rst_n), .din_async(din_async), .tick(tick),
        .hold_count(hold_count), .filt_en(filt_en), .dout(dout)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model: synchronizer as a queue, then run counting on ticks.
    always @(posedge clk) begin
        int smp, need;
        if (!rst_n) begin
            q = '{0, 0}; m_lvl = 0; m_cnt = 0;
        end else begin
            smp  = q[0];
            need = (hold_count == 0) ? 1 : int'(hold_count);
            if (!filt_en) begin
                m_lvl = smp; m_cnt = 0;
            end else if (tick) begin
                if (smp == m_lvl) m_cnt = 0;
                else if (m_cnt + 1 >= need) begin m_lvl = smp; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            void'(q.pop_front());
            q.push_back(int'(din_async));
        end
    end

    // Compare the DUT against the model on every clock.
    always @(negedge clk) begin
        int exp_v;
        if (rst_n && !done) begin
            exp_v = filt_en ? m_lvl : q[0];
            checks++;
            if (int'(dout) != exp_v) begin
                bad++;
                $display("FAIL %s cycle-compare dout=%0d exp=%0d at %0t", phase, dout, exp_v, $time);
            end
        end
    end

    // Strobe generator, driven just after the falling edge.
    always @(negedge clk) begin
        #1;
        if (tick_div > 0) begin
            tick_ctr = (tick_ctr + 1) % tick_div;
            tick = (tick_ctr == 0);
        end else begin
            tick = 1'b0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic expect_out(input string req, input logic e);
        checks++;
        if (dout !== e) begin
            bad++;
            $display("FAIL %s directed dout=%b exp=%b", req, dout, e);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog timeout dout=%b exp=finished", dout);
        finish_run();
    end

    initial begin
        cyc(3);
        expect_out("R1", 1'b0);
        rst_n = 1'b1;
        cyc(2);
        expect_out("R1", 1'b0);

        // R2: bypass latency.
        phase = "R2";
        din_async = 1'b1; cyc(1); expect_out("R2", 1'b0);
        cyc(1); expect_out("R2", 1'b1);
        din_async = 1'b0; cyc(2); expect_out("R2", 1'b0);

        // R8: enable with a steady high input must not glitch.
        phase = "R8";
        din_async = 1'b1; cyc(4);
        hold_count = 8'd5; tick_div = 3; filt_en = 1'b1;
        cyc(1); expect_out("R8", 1'b1);
        cyc(10); expect_out("R8", 1'b1);

        // R4: falling acceptance after five ticks.
        phase = "R4";
        din_async = 1'b0; cyc(6); expect_out("R4", 1'b1);
        cyc(20); expect_out("R4", 1'b0);

        // R3: rising acceptance.
        phase = "R3";
        din_async = 1'b1; cyc(6); expect_out("R3", 1'b0);
        cyc(20); expect_out("R3", 1'b1);
        din_async = 1'b0; cyc(25);

        // R5: disagreeing sample restarts the run.
        phase = "R5";
        din_async = 1'b1; cyc(12);
        din_async = 1'b0; cyc(3);
        din_async = 1'b1; cyc(11);
        din_async = 1'b0; cyc(6);
        expect_out("R5", 1'b0);

        // R6: a pulse that falls entirely between sparse ticks is never seen.
        phase = "R6";
        hold_count = 8'd1; tick_div = 20; cyc(40);
        while (!tick) cyc(1);
        cyc(3); din_async = 1'b1; cyc(3); din_async = 1'b0;
        cyc(25); expect_out("R6", 1'b0);

        // R7: zero threshold accepts on the first differing tick.
        phase = "R7";
        hold_count = 8'd0; tick_div = 1;
        din_async = 1'b1; cyc(2); expect_out("R7", 1'b0);
        cyc(1); expect_out("R7", 1'b1);
        din_async = 1'b0; cyc(4); expect_out("R7", 1'b0);

        // R8 with R3: re-enable in a tick cycle after a bypass period.
        phase = "R8";
        filt_en = 1'b0; din_async = 1'b1; hold_count = 8'd4; tick_div = 2; cyc(5);
        filt_en = 1'b1; cyc(1); expect_out("R8", 1'b1);

        // R3/R4: random input and strobe spacing, judged by the model.
        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            if (i % 300 == 0) begin
                tick_div   = 1 + int'($urandom_range(0, 4));
                hold_count = CW'($urandom_range(0, 6));
                filt_en    = ($urandom_range(0, 9) != 0);
                phase      = (i % 600 == 0) ? "R4" : "R3";
            end
            din_async = ($urandom_range(0, 5) == 0) ? ~din_async : din_async;
            cyc(1);
        end
        finish_run();
    end
endmodule